// File: doc/BRIEF.md
# Multimode up/down position counter

This block keeps the position count for one encoder axis. Count requests arrive from an upstream decoder. Each request is a single-cycle strobe plus a direction bit, and a level gate can block all of them. Two synchronous commands act on the count: a clear, and a load from a preset value.

The preset value plays several roles, depending on the mode. It is the compare target in every mode. It is the upper limit in range-limit mode and the wrap boundary in modulo-N mode. A 3-bit mode field selects one of five counting rules:

- plain binary
- two-digit-per-byte decimal (BCD)
- range-limit, with zero as the floor and the preset as the ceiling
- one-shot, which stops after the first overflow or underflow
- modulo-N, which divides the count rate by preset + 1 in either direction

Events are reported on active-low carry, borrow and compare lines, each one clock wide. Three toggle flags change state one clock after each of those events, so software sampling at any rate can tell whether an event has happened. A sign bit and a direction bit complete the status. Everything runs on one clock.

Top module: `updown_axis_counter`

## Requirements
- R1: After reset the count is 0. Carry, borrow and compare are high (inactive). All three toggle flags and the sign bit are 0, and the direction bit is 1.
- R2: With mode 0, and with the unused modes 5, 6 and 7, counting is binary. An up strobe at all-ones wraps to 0 and drives carry low. A down strobe at 0 wraps to all-ones and drives borrow low. The count and its pulses change at the clock edge that samples the strobe, and each pulse lasts one clock.
- R3: With mode 1, each 4-bit digit counts 0 to 9. An up strobe at all-nines wraps to all-zeros with carry low. A down strobe at all-zeros wraps to all-nines with borrow low.
- R4: With mode 2, an up strobe while count ≥ preset leaves the count unchanged. A down strobe at 0 also leaves the count unchanged. Counting resumes when the strobe direction reverses. Carry and borrow never go low in this mode.
- R5: With mode 3, counting is binary until a wrap. The wrap issues its carry or borrow, and from then on every strobe is ignored until a clear or load command.
- R6: With mode 4, an up strobe while count ≥ preset gives 0 with carry low. A down strobe at 0 gives the preset with borrow low. Otherwise the count steps by one.
- R7: Compare goes low for one clock after every clear, load or count step whose new count equals the preset.
- R8: Three toggle flags invert at the clock edge that ends each pulse, one clock after the pulse starts: flag_bt on borrow, flag_ct on carry and flag_cpt on compare.
- R9: The sign bit goes to 0 with every carry and to 1 with every borrow. The direction bit takes the value of the up input on every strobe accepted by the gate.
- R10: While the gate input is low, strobes leave the count, the direction bit and all pulses unchanged.
- R11: A clear has priority over a load, and a load has priority over a strobe in the same cycle. A strobe that loses to a command has no effect, including on the direction bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 3 | Counting rule: 0 binary, 1 BCD, 2 range-limit, 3 one-shot, 4 modulo-N |
| preset_i | input | WIDTH | Preset, limit and compare value |
| cnt_en_i | input | 1 | Count gate; strobes are ignored while low |
| cnt_stb_i | input | 1 | Single-cycle count request |
| cnt_up_i | input | 1 | Direction of the request: 1 up, 0 down |
| cmd_rst_i | input | 1 | Clear the count to 0 and re-arm one-shot mode |
| cmd_load_i | input | 1 | Load the preset into the count and re-arm one-shot mode |
| count_o | output | WIDTH | Current count |
| carry_n_o | output | 1 | Active-low overflow pulse |
| borrow_n_o | output | 1 | Active-low underflow pulse |
| cmp_n_o | output | 1 | Active-low compare pulse |
| flag_bt_o | output | 1 | Toggles after each borrow |
| flag_ct_o | output | 1 | Toggles after each carry |
| flag_cpt_o | output | 1 | Toggles after each compare |
| sign_o | output | 1 | 1 after an underflow, 0 after an overflow |
| dir_o | output | 1 | Direction of the last accepted strobe |

## Verification
A count strobe can arrive in the same cycle as a clear or a load command. The bench provokes this by driving a strobe together with a load, and a strobe together with both commands. It then checks that the count equals the preset or zero, that no carry or borrow appears, and that the direction bit keeps its earlier value. In one-shot mode a command also coincides with the halted state. The bench checks that a single clear or load both sets the count and makes the very next strobe effective.

// File: rtl/ucnt_pkg.sv
package ucnt_pkg;

    typedef enum logic [2:0] {
        MODE_BIN   = 3'd0,
        MODE_BCD   = 3'd1,
        MODE_RANGE = 3'd2,
        MODE_ONCE  = 3'd3,
        MODE_WRAPN = 3'd4
    } mode_e;

    localparam int unsigned N_TOGGLE = 3;

endpackage

// File: rtl/ucnt_bcd_step.sv
module ucnt_bcd_step #(
    parameter int unsigned DIGITS = 6,
    localparam int unsigned W = DIGITS * 4
) (
    input  logic [W-1:0] val_i,
    input  logic         up_i,
    output logic [W-1:0] res_o,
    output logic         wrap_o
);

    logic [DIGITS:0] chain;

    assign chain[0] = 1'b1;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        logic [3:0] dig;
        logic       at_end;
        logic [3:0] stepped;

        assign dig     = val_i[4*g +: 4];
        assign at_end  = up_i ? (dig >= 4'd9) : (dig == 4'd0);
        assign stepped = at_end ? (up_i ? 4'd0 : 4'd9)
                                : (up_i ? dig + 4'd1 : dig - 4'd1);
        assign res_o[4*g +: 4] = chain[g] ? stepped : dig;
        assign chain[g+1]      = chain[g] & at_end;
    end

    assign wrap_o = chain[DIGITS];

endmodule

// File: rtl/ucnt_step.sv
module ucnt_step
    import ucnt_pkg::*;
#(
    parameter int unsigned WIDTH = 24,
    localparam int unsigned DIGITS = WIDTH / 4
) (
    input  logic [WIDTH-1:0] count_i,
    input  logic [WIDTH-1:0] preset_i,
    input  logic             up_i,
    input  mode_e            mode_i,
    output logic [WIDTH-1:0] next_o,
    output logic             take_o,
    output logic             carry_o,
    output logic             borrow_o
);

    localparam logic [WIDTH-1:0] ALL_ONES = '1;

    logic [WIDTH-1:0] bin_up;
    logic [WIDTH-1:0] bin_dn;
    logic [WIDTH-1:0] bcd_res;
    logic             bcd_wrap;
    logic             is_max;
    logic             is_zero;
    logic             at_top;

    assign bin_up  = count_i + 1'b1;
    assign bin_dn  = count_i - 1'b1;
    assign is_max  = (count_i == ALL_ONES);
    assign is_zero = (count_i == '0);
    assign at_top  = (count_i >= preset_i);

    ucnt_bcd_step #(.DIGITS(DIGITS)) i_bcd (
        .val_i  (count_i),
        .up_i   (up_i),
        .res_o  (bcd_res),
        .wrap_o (bcd_wrap)
    );

    always_comb begin
        next_o   = count_i;
        take_o   = 1'b1;
        carry_o  = 1'b0;
        borrow_o = 1'b0;
        unique case (mode_i)
            MODE_BCD: begin
                next_o   = bcd_res;
                carry_o  = up_i & bcd_wrap;
                borrow_o = ~up_i & bcd_wrap;
            end
            MODE_RANGE: begin
                if (up_i) begin
                    take_o = ~at_top;
                    next_o = at_top ? count_i : bin_up;
                end else begin
                    take_o = ~is_zero;
                    next_o = is_zero ? count_i : bin_dn;
                end
            end
            MODE_WRAPN: begin
                if (up_i) begin
                    next_o  = at_top ? '0 : bin_up;
                    carry_o = at_top;
                end else begin
                    next_o   = is_zero ? preset_i : bin_dn;
                    borrow_o = is_zero;
                end
            end
            default: begin
                next_o   = up_i ? bin_up : bin_dn;
                carry_o  = up_i & is_max;
                borrow_o = ~up_i & is_zero;
            end
        endcase
    end

endmodule

// File: rtl/ucnt_flags.sv
module ucnt_flags #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pulse_i,
    output logic [N-1:0] tog_o
);

    logic [N-1:0] tog_d;
    logic [N-1:0] tog_q;

    always_comb begin
        tog_d = tog_q ^ pulse_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog_q <= '0;
        end else begin
            tog_q <= tog_d;
        end
    end

    assign tog_o = tog_q;

endmodule

// File: rtl/updown_axis_counter.sv
module updown_axis_counter
    import ucnt_pkg::*;
#(
    parameter int unsigned WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       mode_i,
    input  logic [WIDTH-1:0] preset_i,
    input  logic             cnt_en_i,
    input  logic             cnt_stb_i,
    input  logic             cnt_up_i,
    input  logic             cmd_rst_i,
    input  logic             cmd_load_i,
    output logic [WIDTH-1:0] count_o,
    output logic             carry_n_o,
    output logic             borrow_n_o,
    output logic             cmp_n_o,
    output logic             flag_bt_o,
    output logic             flag_ct_o,
    output logic             flag_cpt_o,
    output logic             sign_o,
    output logic             dir_o
);

    typedef struct packed {
        logic [WIDTH-1:0] count;
        logic             halted;
        logic             carry;
        logic             borrow;
        logic             cmp;
        logic             sign;
        logic             dir;
    } state_t;

    state_t st_d;
    state_t st_q;

    mode_e            mode;
    logic [WIDTH-1:0] step_next;
    logic             step_take;
    logic             step_carry;
    logic             step_borrow;
    logic             gated;
    logic             updated;
    logic [N_TOGGLE-1:0] pulses;
    logic [N_TOGGLE-1:0] toggles;

    assign mode  = mode_e'(mode_i);
    assign gated = cnt_en_i & cnt_stb_i;

    ucnt_step #(.WIDTH(WIDTH)) i_step (
        .count_i  (st_q.count),
        .preset_i (preset_i),
        .up_i     (cnt_up_i),
        .mode_i   (mode),
        .next_o   (step_next),
        .take_o   (step_take),
        .carry_o  (step_carry),
        .borrow_o (step_borrow)
    );

    always_comb begin
        st_d        = st_q;
        st_d.carry  = 1'b0;
        st_d.borrow = 1'b0;
        updated     = 1'b0;
        if (cmd_rst_i) begin
            st_d.count  = '0;
            st_d.halted = 1'b0;
            updated     = 1'b1;
        end else if (cmd_load_i) begin
            st_d.count  = preset_i;
            st_d.halted = 1'b0;
            updated     = 1'b1;
        end else if (gated) begin
            st_d.dir = cnt_up_i;
            if (step_take && !(mode == MODE_ONCE && st_q.halted)) begin
                st_d.count  = step_next;
                st_d.carry  = step_carry;
                st_d.borrow = step_borrow;
                updated     = 1'b1;
                if (mode == MODE_ONCE && (step_carry || step_borrow)) begin
                    st_d.halted = 1'b1;
                end
                if (step_carry) begin
                    st_d.sign = 1'b0;
                end
                if (step_borrow) begin
                    st_d.sign = 1'b1;
                end
            end
        end
        st_d.cmp = updated && (st_d.count == preset_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.dir    <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulses = {st_q.borrow, st_q.carry, st_q.cmp};

    ucnt_flags #(.N(N_TOGGLE)) i_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .pulse_i (pulses),
        .tog_o   (toggles)
    );

    assign count_o    = st_q.count;
    assign carry_n_o  = ~st_q.carry;
    assign borrow_n_o = ~st_q.borrow;
    assign cmp_n_o    = ~st_q.cmp;
    assign flag_bt_o  = toggles[2];
    assign flag_ct_o  = toggles[1];
    assign flag_cpt_o = toggles[0];
    assign sign_o     = st_q.sign;
    assign dir_o      = st_q.dir;

endmodule

// File: rtl/updown_axis_counter_chk.sv
module updown_axis_counter_chk #(
    parameter int unsigned WIDTH = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       mode_i,
    input logic [WIDTH-1:0] preset_i,
    input logic             cnt_en_i,
    input logic             cnt_stb_i,
    input logic             cnt_up_i,
    input logic             cmd_rst_i,
    input logic             cmd_load_i,
    input logic [WIDTH-1:0] count_o,
    input logic             carry_n_o,
    input logic             borrow_n_o,
    input logic             cmp_n_o,
    input logic             flag_bt_o,
    input logic             flag_ct_o,
    input logic             flag_cpt_o,
    input logic             sign_o,
    input logic             dir_o
);

    a_r2_carry_from_up_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !carry_n_o |-> $past(cnt_en_i && cnt_stb_i && cnt_up_i && !cmd_rst_i && !cmd_load_i));

    a_r2_borrow_from_down_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !borrow_n_o |-> $past(cnt_en_i && cnt_stb_i && !cnt_up_i && !cmd_rst_i && !cmd_load_i));

    a_r4_range_ceiling_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'd2 && cnt_up_i && count_o >= preset_i && !cmd_rst_i && !cmd_load_i)
        |=> $stable(count_o) && carry_n_o);

    a_r7_compare_matches: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_n_o |-> (count_o == $past(preset_i)));

    a_r8_ct_follows_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_ct_o != $past(flag_ct_o)) |-> $past(!carry_n_o));

    a_r8_bt_follows_borrow: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_bt_o != $past(flag_bt_o)) |-> $past(!borrow_n_o));

    a_r8_cpt_follows_compare: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_cpt_o != $past(flag_cpt_o)) |-> $past(!cmp_n_o));

    a_r9_sign_on_carry: assert property (@(posedge clk) disable iff (!rst_n)
        !carry_n_o |-> !sign_o);

    a_r9_sign_on_borrow: assert property (@(posedge clk) disable iff (!rst_n)
        !borrow_n_o |-> sign_o);

    a_r9_dir_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en_i && cnt_stb_i && !cmd_rst_i && !cmd_load_i) |=> (dir_o == $past(cnt_up_i)));

    a_r10_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en_i && !cmd_rst_i && !cmd_load_i)
        |=> $stable(count_o) && $stable(dir_o) && carry_n_o && borrow_n_o);

    a_r11_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rst_i |=> (count_o == '0) && carry_n_o && borrow_n_o);

    a_r11_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_load_i && !cmd_rst_i) |=> (count_o == $past(preset_i)) && !cmp_n_o);

endmodule

bind updown_axis_counter updown_axis_counter_chk #(.WIDTH(WIDTH)) i_chk (.*);

// File: tb/test_updown_axis_counter.sv
`timescale 1ns/1ps
module test_updown_axis_counter;

    localparam int W   = 8;
    localparam int MAX = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [2:0]   mode;
    logic [W-1:0] preset;
    logic         cnt_en, cnt_stb, cnt_up, cmd_rst, cmd_load;
    logic [W-1:0] count;
    logic         carry_n, borrow_n, cmp_n, f_bt, f_ct, f_cpt, sign, dir;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    int m_cnt, m_halt, m_sign, m_dir, m_bt, m_ct, m_cpt, p_c, p_b, p_cmp;

    always #2 clk = ~clk;

    updown_axis_counter #(.WIDTH(W)) i_updown_axis_counter (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .preset_i(preset),
        .cnt_en_i(cnt_en), .cnt_stb_i(cnt_stb), .cnt_up_i(cnt_up),
        .cmd_rst_i(cmd_rst), .cmd_load_i(cmd_load),
        .count_o(count), .carry_n_o(carry_n), .borrow_n_o(borrow_n), .cmp_n_o(cmp_n),
        .flag_bt_o(f_bt), .flag_ct_o(f_ct), .flag_cpt_o(f_cpt),
        .sign_o(sign), .dir_o(dir)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, "count", int'(count), m_cnt);
        chk(req, "carry_n", int'(carry_n), p_c ? 0 : 1);
        chk(req, "borrow_n", int'(borrow_n), p_b ? 0 : 1);
        chk(req, "cmp_n", int'(cmp_n), p_cmp ? 0 : 1);
        chk(req, "sign", int'(sign), m_sign);
        chk(req, "dir", int'(dir), m_dir);
        chk(req, "flags bt/ct/cpt", int'({f_bt, f_ct, f_cpt}), (m_bt << 2) | (m_ct << 1) | m_cpt);
    endtask

    function automatic int to_dec(input int v);
        return ((v >> 4) & 15) * 10 + (v & 15);
    endfunction

    function automatic int to_bcd(input int v);
        return ((v / 10) << 4) | (v % 10);
    endfunction

    task automatic op(input bit r, input bit l, input bit s, input bit u, input bit e, input string req);
        int pv;
        int md;
        m_bt  ^= p_b;
        m_ct  ^= p_c;
        m_cpt ^= p_cmp;
        p_b = 0; p_c = 0; p_cmp = 0;
        @(negedge clk);
        cmd_rst = r; cmd_load = l; cnt_stb = s; cnt_up = u; cnt_en = e;
        pv = int'(preset);
        md = int'(mode);
        @(negedge clk);
        cmd_rst = 0; cmd_load = 0; cnt_stb = 0; cnt_up = 0; cnt_en = 1;
        if (r) begin
            m_cnt = 0; m_halt = 0; p_cmp = (pv == 0);
        end else if (l) begin
            m_cnt = pv; m_halt = 0; p_cmp = 1;
        end else if (e && s) begin
            bit moved = 1;
            m_dir = u;
            case (md)
                1: begin
                    int dv = to_dec(m_cnt);
                    if (u) begin
                        if (dv == 99) begin dv = 0; p_c = 1; end else dv++;
                    end else begin
                        if (dv == 0) begin dv = 99; p_b = 1; end else dv--;
                    end
                    m_cnt = to_bcd(dv);
                end
                2: begin
                    if (u) begin
                        if (m_cnt < pv) m_cnt++; else moved = 0;
                    end else begin
                        if (m_cnt > 0) m_cnt--; else moved = 0;
                    end
                end
                4: begin
                    if (u) begin
                        if (m_cnt >= pv) begin m_cnt = 0; p_c = 1; end else m_cnt++;
                    end else begin
                        if (m_cnt == 0) begin m_cnt = pv; p_b = 1; end else m_cnt--;
                    end
                end
                default: begin
                    if (md == 3 && m_halt != 0) moved = 0;
                    else if (u) begin
                        if (m_cnt == MAX) begin m_cnt = 0; p_c = 1; end else m_cnt++;
                    end else begin
                        if (m_cnt == 0) begin m_cnt = MAX; p_b = 1; end else m_cnt--;
                    end
                    if (md == 3 && (p_c || p_b)) m_halt = 1;
                end
            endcase
            if (p_c) m_sign = 0;
            if (p_b) m_sign = 1;
            p_cmp = moved && (m_cnt == pv);
        end
        check_all(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; mode = 3'd0; preset = 8'h37;
        cnt_en = 1; cnt_stb = 0; cnt_up = 0; cmd_rst = 0; cmd_load = 0;
        m_cnt = 0; m_halt = 0; m_sign = 0; m_dir = 1;
        m_bt = 0; m_ct = 0; m_cpt = 0; p_c = 0; p_b = 0; p_cmp = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_all("R1");

        // R2 binary sweep up through the wrap and back down
        for (int i = 0; i < 258; i++) op(0, 0, 1, 1, 1, "R2");
        for (int i = 0; i < 260; i++) op(0, 0, 1, 0, 1, "R2");
        mode = 3'd6;
        op(0, 0, 1, 1, 1, "R2");
        op(0, 0, 1, 0, 1, "R2");
        mode = 3'd7;
        for (int i = 0; i < 4; i++) op(0, 0, 1, 0, 1, "R2");

        // R10 gate low: strobes ignored
        mode = 3'd0;
        op(0, 0, 1, 1, 0, "R10");
        op(0, 0, 1, 0, 0, "R10");

        // R3 decimal sweep
        mode = 3'd1; preset = 8'h42;
        op(1, 0, 0, 0, 1, "R3");
        for (int i = 0; i < 102; i++) op(0, 0, 1, 1, 1, "R3");
        for (int i = 0; i < 103; i++) op(0, 0, 1, 0, 1, "R3");

        // R6 modulo-N with several presets, both directions
        mode = 3'd4;
        foreach (preset_list[k]) begin
            preset = preset_list[k];
            op(0, 1, 0, 0, 1, "R6");
            for (int i = 0; i < 2 * int'(preset_list[k]) + 3; i++) op(0, 0, 1, 1, 1, "R6");
            for (int i = 0; i < 2 * int'(preset_list[k]) + 3; i++) op(0, 0, 1, 0, 1, "R6");
        end

        // R4 range limit: freeze at both ends, resume on reversal
        mode = 3'd2; preset = 8'd5;
        op(1, 0, 0, 0, 1, "R4");
        for (int i = 0; i < 8; i++) op(0, 0, 1, 1, 1, "R4");
        op(0, 0, 1, 0, 1, "R4");
        op(0, 0, 1, 1, 1, "R4");
        for (int i = 0; i < 8; i++) op(0, 0, 1, 0, 1, "R4");
        op(0, 0, 1, 1, 1, "R4");

        // R5 one-shot: halt after wrap, re-armed by clear or load
        mode = 3'd3; preset = 8'hFD;
        op(0, 1, 0, 0, 1, "R5");
        for (int i = 0; i < 5; i++) op(0, 0, 1, 1, 1, "R5");
        op(0, 0, 1, 0, 1, "R5");
        op(1, 0, 0, 0, 1, "R5");
        for (int i = 0; i < 3; i++) op(0, 0, 1, 0, 1, "R5");
        op(0, 1, 0, 0, 1, "R5");
        op(0, 0, 1, 1, 1, "R5");

        // R11 commands beat a simultaneous strobe; R7 compare on load
        mode = 3'd0; preset = 8'h80;
        op(0, 0, 1, 1, 1, "R11");
        op(0, 1, 1, 0, 1, "R11");
        op(1, 1, 1, 0, 1, "R11");
        op(0, 1, 1, 1, 1, "R7");
        op(0, 0, 1, 0, 1, "R7");
        op(0, 0, 1, 1, 1, "R7");
        op(0, 0, 0, 0, 1, "R8");
        op(0, 0, 0, 0, 1, "R8");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    logic [W-1:0] preset_list [4] = '{8'd0, 8'd1, 8'd5, 8'd200};

endmodule